// File: doc/BRIEF.md
# Flag-Producing Integer ALU with Branch Condition Check

This block is the integer arithmetic and logic stage of a processor datapath. It takes two two's-complement operands, a four-bit operation code and an external carry bit. It produces a combinational result and a strobe that says whether the result is to be written back. The arithmetic group covers add, subtract, add with carry, subtract with borrow, increment, decrement and negate. The logic group covers complement, AND, OR and XOR. Compare and test set the flags but write nothing back.

Four condition flags are held in a register: sign, zero, overflow and carry. The register loads on a clock edge only when the update enable is high. A branch condition checker reads the stored flags and a four-bit condition code, and answers whether the branch is taken. To chain multi-word arithmetic, the stored carry is fed back to the carry input, so the next word's add with carry or subtract with borrow continues the operation.

Top module: `flag_alu`

## Requirements
- R1: Opcodes 0 add (a+b), 1 subtract (a-b), 2 add with carry (a+b+carry_in) and 3 subtract with borrow (a-b-(1-carry_in)) give the result modulo 2^WIDTH.
- R2: Opcodes 4 increment (a+1), 5 decrement (a-1), 6 negate (0-a) and 7 complement (bitwise NOT a) give the result modulo 2^WIDTH. Operand b is ignored by these four.
- R3: Opcodes 8 AND, 9 OR and 10 XOR give the bitwise result of a and b.
- R4: result_we is high for opcodes 0 to 10. It is low for opcodes 11 (compare, flags as a-b) and 12 (test, flags as a AND b). It is low for the reserved opcodes 13 to 15, which also drive result to zero and never change the flags.
- R5: After an update, flag_n equals the most significant bit of the operation's value and flag_z is 1 exactly when every bit of that value is 0.
- R6: After an arithmetic update, flag_c is the unsigned carry out. For the subtracting forms (1, 3, 5, 6, 11), C=1 means no borrow: for example, C=1 after subtract exactly when a >= b unsigned.
- R7: After an arithmetic update, flag_v is 1 exactly when the signed two's-complement value of the operation falls outside the WIDTH-bit range. This is the case where the carry into the sign bit differs from the carry out of it.
- R8: Opcodes 7, 8, 9, 10 and 12 clear flag_v and leave flag_c at its old value.
- R9: A synchronous active-high reset clears all four flags. The flags change only on a rising clock edge with flag_we high and a defined opcode.
- R10: Condition codes read the stored flags: 0 Z=1, 1 Z=0, 2 C=1, 3 C=0, 4 N=0, 5 N=1, 6 V=1, 7 V=0, 8 always taken, 9 to 15 never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| opcode | input | 4 | Operation select |
| carry_in | input | 1 | Carry for add with carry and subtract with borrow |
| flag_we | input | 1 | Flag register update enable |
| result | output | WIDTH | Combinational result |
| result_we | output | 1 | High when the result is to be written back |
| flag_n | output | 1 | Stored sign flag |
| flag_z | output | 1 | Stored zero flag |
| flag_v | output | 1 | Stored overflow flag |
| flag_c | output | 1 | Stored carry flag |
| cond | input | 4 | Branch condition code |
| taken | output | 1 | Branch condition outcome on the stored flags |

## Verification
The hardest cases to reach are the ones where the flags must keep their old values. Examples are the carry flag across a logic operation and all flags across a disabled or reserved cycle. A wrong answer there only shows up if the earlier state differs from what a fresh update would have written. The bench sweeps every operand pair, both carry inputs and all sixteen opcodes on a 4-bit instance. It lowers flag_we on a fixed fraction of the vectors, so the flags going into each cycle are left by a varied history. After each step it compares all sixteen condition codes against its own running model of the flags.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,  OP_SUB = 4'd1,  OP_ADC = 4'd2,  OP_SBC = 4'd3,
        OP_INC = 4'd4,  OP_DEC = 4'd5,  OP_NEG = 4'd6,  OP_NOT = 4'd7,
        OP_AND = 4'd8,  OP_OR  = 4'd9,  OP_XOR = 4'd10, OP_CMP = 4'd11,
        OP_TST = 4'd12, OP_RSV13 = 4'd13, OP_RSV14 = 4'd14, OP_RSV15 = 4'd15
    } alu_op_e;

    typedef enum logic [3:0] {
        CC_ZS = 4'd0, CC_ZC = 4'd1, CC_CS = 4'd2, CC_CC = 4'd3,
        CC_PL = 4'd4, CC_MI = 4'd5, CC_VS = 4'd6, CC_VC = 4'd7,
        CC_AL = 4'd8
    } cond_e;

    typedef enum logic [1:0] {
        K_NONE  = 2'd0,
        K_ARITH = 2'd1,
        K_LOGIC = 2'd2
    } op_kind_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    function automatic logic writes_result(alu_op_e op);
        return (op <= OP_XOR);
    endfunction

endpackage

// File: rtl/flag_adder.sv
module flag_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             c_into_msb,
    output logic             cout
);
    localparam int LOW = WIDTH - 1;

    logic [LOW:0] low_sum;
    logic [1:0]   top_sum;

    // split at the sign bit so the carry entering it is visible
    always_comb begin
        low_sum    = {1'b0, x[LOW-1:0]} + {1'b0, y[LOW-1:0]} + {{LOW{1'b0}}, cin};
        c_into_msb = low_sum[LOW];
        top_sum    = {1'b0, x[LOW]} + {1'b0, y[LOW]} + {1'b0, c_into_msb};
        sum        = {top_sum[0], low_sum[LOW-1:0]};
        cout       = top_sum[1];
    end
endmodule

// File: rtl/flag_op_decode.sv
module flag_op_decode
    import alu_flags_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] add_x,
    output logic [WIDTH-1:0] add_y,
    output logic             add_c,
    output logic [WIDTH-1:0] logic_val,
    output op_kind_e         kind
);
    localparam logic [WIDTH-1:0] ZERO = '0;
    localparam logic [WIDTH-1:0] ONES = '1;

    always_comb begin
        add_x     = a;
        add_y     = b;
        add_c     = 1'b0;
        logic_val = ZERO;
        kind      = K_ARITH;
        unique case (op)
            OP_ADD: ;
            OP_SUB, OP_CMP: begin add_y = ~b; add_c = 1'b1; end
            OP_ADC: add_c = carry_in;
            OP_SBC: begin add_y = ~b; add_c = carry_in; end
            OP_INC: begin add_y = ZERO; add_c = 1'b1; end
            OP_DEC: add_y = ONES;
            OP_NEG: begin add_x = ZERO; add_y = ~a; add_c = 1'b1; end
            OP_NOT: begin logic_val = ~a;    kind = K_LOGIC; end
            OP_AND, OP_TST: begin logic_val = a & b; kind = K_LOGIC; end
            OP_OR:  begin logic_val = a | b; kind = K_LOGIC; end
            OP_XOR: begin logic_val = a ^ b; kind = K_LOGIC; end
            default: kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/flag_cond_eval.sv
module flag_cond_eval
    import alu_flags_pkg::*;
(
    input  logic [3:0] cond,
    input  flags_t     f,
    output logic       taken
);
    always_comb begin
        unique case (cond)
            CC_ZS:   taken = f.z;
            CC_ZC:   taken = !f.z;
            CC_CS:   taken = f.c;
            CC_CC:   taken = !f.c;
            CC_PL:   taken = !f.n;
            CC_MI:   taken = f.n;
            CC_VS:   taken = f.v;
            CC_VC:   taken = !f.v;
            CC_AL:   taken = 1'b1;
            default: taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import alu_flags_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [3:0]       opcode,
    input  logic             carry_in,
    input  logic             flag_we,
    output logic [WIDTH-1:0] result,
    output logic             result_we,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_v,
    output logic             flag_c,
    input  logic [3:0]       cond,
    output logic             taken
);
    localparam int MSB = WIDTH - 1;

    alu_op_e          op;
    op_kind_e         kind;
    logic [WIDTH-1:0] add_x, add_y, sum, logic_val, value;
    logic             add_c, c_msb, cout;
    flags_t           flags_q, flags_d;

    assign op = alu_op_e'(opcode);

    flag_op_decode #(.WIDTH(WIDTH)) decode_i (
        .op(op), .a(op_a), .b(op_b), .carry_in(carry_in),
        .add_x(add_x), .add_y(add_y), .add_c(add_c),
        .logic_val(logic_val), .kind(kind)
    );

    flag_adder #(.WIDTH(WIDTH)) adder_i (
        .x(add_x), .y(add_y), .cin(add_c),
        .sum(sum), .c_into_msb(c_msb), .cout(cout)
    );

    always_comb begin
        unique case (kind)
            K_ARITH: value = sum;
            K_LOGIC: value = logic_val;
            default: value = '0;
        endcase
        flags_d.n = value[MSB];
        flags_d.z = (value == '0);
        flags_d.v = (kind == K_ARITH) ? (c_msb ^ cout) : 1'b0;
        flags_d.c = (kind == K_ARITH) ? cout : flags_q.c;
    end

    assign result    = value;
    assign result_we = writes_result(op);

    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= '0;
        else if (flag_we && kind != K_NONE)
            flags_q <= flags_d;
    end

    assign flag_n = flags_q.n;
    assign flag_z = flags_q.z;
    assign flag_v = flags_q.v;
    assign flag_c = flags_q.c;

    flag_cond_eval cond_i (.cond(cond), .f(flags_q), .taken(taken));

    a_r9_hold_when_disabled: assert property (@(posedge clk) disable iff (rst)
        !flag_we |=> $stable(flags_q));

    a_r4_reserved_no_update: assert property (@(posedge clk) disable iff (rst)
        (opcode > 4'd12) |=> $stable(flags_q));

    a_r4_no_writeback: assert property (@(posedge clk) disable iff (rst)
        (opcode == 4'd11 || opcode == 4'd12) |-> !result_we);

    a_r8_logic_clears_v: assert property (@(posedge clk) disable iff (rst)
        (flag_we && kind == K_LOGIC) |=> !flag_v);

    a_r8_logic_keeps_c: assert property (@(posedge clk) disable iff (rst)
        (flag_we && kind == K_LOGIC) |=> (flag_c == $past(flag_c)));

    a_r5_zero_flag: assert property (@(posedge clk) disable iff (rst)
        (flag_we && kind != K_NONE) |=> (flag_z == ($past(result) == '0)));

    a_r7_add_overflow: assert property (@(posedge clk) disable iff (rst)
        (flag_we && opcode == 4'd0 && op_a[MSB] == op_b[MSB] && result[MSB] != op_a[MSB])
        |=> flag_v);

    a_r10_always_taken: assert property (@(posedge clk) disable iff (rst)
        (cond == 4'd8) |-> taken);
endmodule

// File: tb/flag_alu_tb_top.sv
module flag_alu_tb_top;
    localparam int W    = 4;
    localparam int FULL = 1 << W;
    localparam int HALF = 1 << (W - 1);
    localparam int MASK = FULL - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic [3:0]   opcode = 4'd0, cond = 4'd0;
    logic         carry_in = 1'b0, flag_we = 1'b0;
    logic [W-1:0] result;
    logic         result_we, flag_n, flag_z, flag_v, flag_c, taken;

    int n_checks = 0;
    int n_fail   = 0;
    bit m_n = 0, m_z = 0, m_v = 0, m_c = 0;

    always #10 clk = ~clk;

    flag_alu #(.WIDTH(W)) dut_i (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .opcode(opcode),
        .carry_in(carry_in), .flag_we(flag_we), .result(result),
        .result_we(result_we), .flag_n(flag_n), .flag_z(flag_z),
        .flag_v(flag_v), .flag_c(flag_c), .cond(cond), .taken(taken)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            if (n_fail <= 20)
                $display("FAIL %s: actual %0d expected %0d (op %0d a %0d b %0d cin %0d)",
                         tag, act, exp, opcode, op_a, op_b, carry_in);
        end
    endtask

    function automatic int sgn(int u);
        return (u >= HALF) ? u - FULL : u;
    endfunction

    function automatic bit cond_model(int cc);
        case (cc)
            0: return m_z;   1: return !m_z;
            2: return m_c;   3: return !m_c;
            4: return !m_n;  5: return m_n;
            6: return m_v;   7: return !m_v;
            8: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check_flags(input string tag);
        check(flag_n == m_n, {tag, " N"}, flag_n, m_n);
        check(flag_z == m_z, {tag, " Z"}, flag_z, m_z);
        check(flag_v == m_v, {tag, " V"}, flag_v, m_v);
        check(flag_c == m_c, {tag, " C"}, flag_c, m_c);
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        check_flags("R9 reset");

        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < FULL; a++) begin
                for (int b = 0; b < FULL; b++) begin
                    for (int ci = 0; ci < 2; ci++) begin
                        int ua, ub, sa, sb, uv, sv;
                        bit arith, logic_op, we_exp, cexp;
                        ua = a; ub = b; sa = sgn(a); sb = sgn(b);
                        arith = 1; logic_op = 0; uv = 0; sv = 0; cexp = 0;
                        case (op)
                            0:  begin uv = ua + ub;            sv = sa + sb;            cexp = (uv > MASK); end
                            1, 11: begin uv = ua - ub;         sv = sa - sb;            cexp = (ua >= ub); end
                            2:  begin uv = ua + ub + ci;       sv = sa + sb + ci;       cexp = (uv > MASK); end
                            3:  begin uv = ua - ub - (1 - ci); sv = sa - sb - (1 - ci); cexp = (uv >= 0); end
                            4:  begin uv = ua + 1;             sv = sa + 1;             cexp = (ua == MASK); end
                            5:  begin uv = ua - 1;             sv = sa - 1;             cexp = (ua != 0); end
                            6:  begin uv = -ua;                sv = -sa;                cexp = (ua == 0); end
                            7:  begin uv = ~ua;      arith = 0; logic_op = 1; end
                            8, 12: begin uv = ua & ub; arith = 0; logic_op = 1; end
                            9:  begin uv = ua | ub;  arith = 0; logic_op = 1; end
                            10: begin uv = ua ^ ub;  arith = 0; logic_op = 1; end
                            default: begin uv = 0; arith = 0; end
                        endcase
                        uv = uv & MASK;
                        we_exp = (op <= 10);

                        @(negedge clk);
                        op_a = W'(a); op_b = W'(b); opcode = 4'(op); carry_in = ci[0];
                        // flag_we low on one vector in eight: R9
                        flag_we = !((a & 3) == 3 && (b & 1) == 1);
                        #1;
                        if (op <= 3)
                            check(result == W'(uv), "R1 result", result, uv);
                        else if (op <= 7)
                            check(result == W'(uv), "R2 result", result, uv);
                        else if (op <= 10)
                            check(result == W'(uv), "R3 result", result, uv);
                        else if (op >= 13)
                            check(result == '0, "R4 reserved result", result, 0);
                        check(result_we == we_exp, "R4 write strobe", result_we, we_exp);

                        if (flag_we && (arith || logic_op)) begin
                            m_n = uv[W-1];
                            m_z = (uv == 0);
                            if (arith) begin
                                m_v = (sv < -HALF) || (sv > HALF - 1);
                                m_c = cexp;
                            end else begin
                                m_v = 1'b0;
                            end
                        end
                        @(posedge clk);
                        @(negedge clk);
                        if (!flag_we)
                            check_flags("R9 hold");
                        else if (op >= 13)
                            check_flags("R4 reserved hold");
                        else if (logic_op)
                            check_flags("R8 R5 logic flags");
                        else begin
                            check(flag_n == m_n, "R5 N", flag_n, m_n);
                            check(flag_z == m_z, "R5 Z", flag_z, m_z);
                            check(flag_c == m_c, "R6 C", flag_c, m_c);
                            check(flag_v == m_v, "R7 V", flag_v, m_v);
                        end
                        for (int cc = 0; cc < 16; cc++) begin
                            cond = 4'(cc);
                            #1;
                            check(taken == cond_model(cc), "R10 taken", taken, cond_model(cc));
                        end
                    end
                end
            end
        end

        // R9: reset clears flags that were set
        @(negedge clk);
        op_a = 4'd0; op_b = 4'd1; opcode = 4'd1; flag_we = 1'b1;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_n = 0; m_z = 0; m_v = 0; m_c = 0;
        check_flags("R9 reset again");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule